// File: doc/BRIEF.md
# Block-Handoff Dual-Clock FIFO

This block carries 16-bit words from a producer clock domain into a consumer clock domain. It does not pass word pointers between the domains. The storage is cut into a fixed number of equal blocks, and ownership of a whole block changes hands at once. The producer fills the block it currently owns and then commits it by raising that block's full flag. The consumer sees the flag through a two-stage synchronizer and drains the block word by word. When the last word has been fetched, the consumer raises an acknowledge that travels back through another two-stage synchronizer.

The flags and acknowledges follow a four-phase exchange, so a block goes back to the producer only after both signals have returned low. The consumer therefore sees data in whole-block batches. A block that is only partly written is never visible to it. The producer stalls when the block it would write next is still held on the read side. Writes rejected by a full FIFO and reads issued on an empty output are latched in sticky error flags. Neither changes the stored data or any pointer.

The read port shows its data ahead of the request. `rd_valid` says that `rd_data` holds a word. A pulse on `rd_next` consumes that word, and the following word appears at the next read-clock edge. Tying `rd_next` to `rd_valid` drains one word per read clock.

Top module: `block_handoff_fifo`

## Requirements
- R1: After reset, `wr_ready` is 1, and `rd_valid`, `wr_err` and `rd_err` are all 0.
- R2: Words leave the read port in exactly the order they were accepted, with all 16 bits unchanged. This holds across block boundaries and across wrap-around from the last block back to block 0.
- R3: None of the words of a block becomes valid at the read port until the final word of that block has been written. A block with BLK_WORDS-1 words written leaves `rd_valid` low indefinitely.
- R4: Once a block is committed, `rd_valid` rises within a few read clocks. While `rd_next` is held high, one word is consumed on every read clock until the committed data runs out.
- R5: The FIFO holds exactly NUM_BLKS*BLK_WORDS words. After that many writes with no reads, `wr_ready` is 0.
- R6: A write attempted while `wr_ready` is 0 is discarded. It sets `wr_err`, which then stays at 1 until reset.
- R7: `rd_next` asserted while `rd_valid` is 0 sets `rd_err`, which stays at 1 until reset. No word is produced or lost as a result.
- R8: When the reader has fetched every word of a block, that block returns to the writer, and `wr_ready` rises again within a bounded number of write clocks.
- R9: While `rd_valid` is 1 and `rd_next` is 0, `rd_valid` stays at 1 and `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Offer `wr_data` at this write-clock edge |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | The current write block has space |
| wr_err | output | 1 | Sticky: a write was offered while not ready |
| rd_next | input | 1 | Consume the word on `rd_data` |
| rd_data | output | DATA_W | Word at the head of the FIFO |
| rd_valid | output | 1 | `rd_data` holds a valid word |
| rd_err | output | 1 | Sticky: `rd_next` was raised with no valid word |

## Verification
The bench holds a block one word short of complete and watches the read port for many read clocks. A design that published words before commit would raise `rd_valid` early. It then fills every block and offers one more word. A design with an off-by-one capacity, or one that stored the rejected word, would leave `wr_ready` high or deliver a stray word later in the stream. A streaming drain with `rd_next` held high shows whether the output register stalls or skips words at the end of a block. Repeated full-depth rounds test the wrap from the last block to the first, where a broken acknowledge exchange would either hang the writer or let it overwrite an undrained block.

// File: rtl/bhf_pkg.sv
package bhf_pkg;
    localparam int DEF_DATA_W    = 16;
    localparam int DEF_BLK_WORDS = 256;
    localparam int DEF_NUM_BLKS  = 4;

    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction
endpackage

// File: rtl/bhf_sync2.sv
module bhf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stable;
endmodule

// File: rtl/bhf_dpram.sv
module bhf_dpram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = bhf_pkg::idx_width(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (re) rdata_q <= cells[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bhf_wr_side.sv
module bhf_wr_side #(
    parameter int BLK_WORDS = 256,
    parameter int NUM_BLKS  = 4,
    localparam int BIDX_W = bhf_pkg::idx_width(NUM_BLKS),
    localparam int OFS_W  = bhf_pkg::idx_width(BLK_WORDS)
) (
    input  logic                wr_clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_BLKS-1:0] ack_sync,
    output logic                wr_ready,
    output logic                wr_err,
    output logic [NUM_BLKS-1:0] full_flags,
    output logic                mem_we,
    output logic [BIDX_W-1:0]   mem_blk,
    output logic [OFS_W-1:0]    mem_ofs
);
    localparam logic [OFS_W-1:0]  LAST_OFS = OFS_W'(BLK_WORDS - 1);
    localparam logic [BIDX_W-1:0] LAST_BLK = BIDX_W'(NUM_BLKS - 1);

    typedef struct packed {
        logic [BIDX_W-1:0]   blk;
        logic [OFS_W-1:0]    ofs;
        logic [NUM_BLKS-1:0] full;
        logic                err;
    } wstate_t;

    wstate_t s_d, s_q;
    logic    cur_free;
    logic    accept;

    always_comb begin
        s_d      = s_q;
        cur_free = !s_q.full[s_q.blk] && !ack_sync[s_q.blk];
        accept   = wr_en && cur_free;

        for (int b = 0; b < NUM_BLKS; b++) begin
            if (s_q.full[b] && ack_sync[b]) s_d.full[b] = 1'b0;
        end

        if (wr_en && !cur_free) s_d.err = 1'b1;

        if (accept) begin
            if (s_q.ofs == LAST_OFS) begin
                s_d.full[s_q.blk] = 1'b1;
                s_d.ofs           = '0;
                s_d.blk           = (s_q.blk == LAST_BLK) ? '0 : s_q.blk + 1'b1;
            end else begin
                s_d.ofs = s_q.ofs + 1'b1;
            end
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_ready   = cur_free;
    assign wr_err     = s_q.err;
    assign full_flags = s_q.full;
    assign mem_we     = accept;
    assign mem_blk    = s_q.blk;
    assign mem_ofs    = s_q.ofs;

    assert_wr_err_sticky_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    assert_reject_keeps_ptr_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> ($stable(mem_blk) && $stable(mem_ofs)));

    for (genvar g = 0; g < NUM_BLKS; g++) begin : g_full_chk
        assert_commit_only_free_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
            $rose(full_flags[g]) |-> $past(!ack_sync[g]));
    end
endmodule

// File: rtl/bhf_rd_side.sv
module bhf_rd_side #(
    parameter int DATA_W    = 16,
    parameter int BLK_WORDS = 256,
    parameter int NUM_BLKS  = 4,
    localparam int BIDX_W = bhf_pkg::idx_width(NUM_BLKS),
    localparam int OFS_W  = bhf_pkg::idx_width(BLK_WORDS)
) (
    input  logic                rd_clk,
    input  logic                rst_n,
    input  logic                rd_next,
    input  logic [NUM_BLKS-1:0] full_sync,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                rd_err,
    output logic [NUM_BLKS-1:0] ack_flags,
    output logic                mem_re,
    output logic [BIDX_W-1:0]   mem_blk,
    output logic [OFS_W-1:0]    mem_ofs
);
    localparam logic [OFS_W-1:0]  LAST_OFS = OFS_W'(BLK_WORDS - 1);
    localparam logic [BIDX_W-1:0] LAST_BLK = BIDX_W'(NUM_BLKS - 1);

    typedef struct packed {
        logic [BIDX_W-1:0]   blk;
        logic [OFS_W-1:0]    ofs;
        logic [NUM_BLKS-1:0] ack;
        logic                valid;
        logic                err;
    } rstate_t;

    rstate_t s_d, s_q;
    logic    readable;
    logic    fetch;

    always_comb begin
        s_d      = s_q;
        readable = full_sync[s_q.blk] && !s_q.ack[s_q.blk];
        fetch    = readable && (!s_q.valid || rd_next);

        for (int b = 0; b < NUM_BLKS; b++) begin
            if (s_q.ack[b] && !full_sync[b]) s_d.ack[b] = 1'b0;
        end

        if (rd_next && !s_q.valid) s_d.err = 1'b1;

        if (fetch) begin
            s_d.valid = 1'b1;
            if (s_q.ofs == LAST_OFS) begin
                s_d.ack[s_q.blk] = 1'b1;
                s_d.ofs          = '0;
                s_d.blk          = (s_q.blk == LAST_BLK) ? '0 : s_q.blk + 1'b1;
            end else begin
                s_d.ofs = s_q.ofs + 1'b1;
            end
        end else if (rd_next && s_q.valid) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid  = s_q.valid;
    assign rd_err    = s_q.err;
    assign ack_flags = s_q.ack;
    assign mem_re    = fetch;
    assign mem_blk   = s_q.blk;
    assign mem_ofs   = s_q.ofs;

    assert_hold_word_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_valid && !rd_next) |=> (rd_valid && $stable(rd_data)));

    assert_rd_err_sticky_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_err |=> rd_err);

    for (genvar g = 0; g < NUM_BLKS; g++) begin : g_ack_chk
        assert_ack_after_commit_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
            $rose(ack_flags[g]) |-> $past(full_sync[g]));
    end
endmodule

// File: rtl/block_handoff_fifo.sv
module block_handoff_fifo #(
    parameter int DATA_W    = bhf_pkg::DEF_DATA_W,
    parameter int BLK_WORDS = bhf_pkg::DEF_BLK_WORDS,
    parameter int NUM_BLKS  = bhf_pkg::DEF_NUM_BLKS
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_err,
    input  logic              rd_next,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_err
);
    localparam int DEPTH  = NUM_BLKS * BLK_WORDS;
    localparam int ADDR_W = bhf_pkg::idx_width(DEPTH);
    localparam int BIDX_W = bhf_pkg::idx_width(NUM_BLKS);
    localparam int OFS_W  = bhf_pkg::idx_width(BLK_WORDS);

    logic [NUM_BLKS-1:0] full_flags, full_sync;
    logic [NUM_BLKS-1:0] ack_flags, ack_sync;
    logic                mem_we, mem_re;
    logic [BIDX_W-1:0]   w_blk, r_blk;
    logic [OFS_W-1:0]    w_ofs, r_ofs;
    logic [ADDR_W-1:0]   waddr, raddr;

    bhf_wr_side #(.BLK_WORDS(BLK_WORDS), .NUM_BLKS(NUM_BLKS)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .ack_sync(ack_sync),
        .wr_ready(wr_ready), .wr_err(wr_err), .full_flags(full_flags),
        .mem_we(mem_we), .mem_blk(w_blk), .mem_ofs(w_ofs)
    );

    bhf_rd_side #(.DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS), .NUM_BLKS(NUM_BLKS)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_next(rd_next), .full_sync(full_sync),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err), .ack_flags(ack_flags),
        .mem_re(mem_re), .mem_blk(r_blk), .mem_ofs(r_ofs)
    );

    bhf_sync2 #(.W(NUM_BLKS)) u_full_to_rd (
        .clk(rd_clk), .rst_n(rst_n), .d(full_flags), .q(full_sync)
    );

    bhf_sync2 #(.W(NUM_BLKS)) u_ack_to_wr (
        .clk(wr_clk), .rst_n(rst_n), .d(ack_flags), .q(ack_sync)
    );

    assign waddr = ADDR_W'(w_blk) * ADDR_W'(BLK_WORDS) + ADDR_W'(w_ofs);
    assign raddr = ADDR_W'(r_blk) * ADDR_W'(BLK_WORDS) + ADDR_W'(r_ofs);

    bhf_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .re(mem_re), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/block_handoff_fifo_bench.sv
module block_handoff_fifo_bench;
    localparam int DW  = 16;
    localparam int BW  = 4;
    localparam int NB  = 3;
    localparam int CAP = BW * NB;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n  = 1'b0;
    logic          wr_en  = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, wr_err;
    logic          rd_next = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    block_handoff_fifo #(.DATA_W(DW), .BLK_WORDS(BW), .NUM_BLKS(NB)) u_block_handoff_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .wr_err(wr_err),
        .rd_next(rd_next), .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input logic [DW-1:0] v, input string req);
        int n = 0;
        @(negedge wr_clk);
        while (!wr_ready && n < 300) begin
            @(negedge wr_clk);
            n++;
        end
        if (!wr_ready) check(1'b0, req, 0, 1);
        wr_en   = 1'b1;
        wr_data = v;
        exp_q.push_back(v);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_check(input string req);
        int n = 0;
        logic [DW-1:0] e;
        @(negedge rd_clk);
        while (!rd_valid && n < 300) begin
            @(negedge rd_clk);
            n++;
        end
        e = exp_q.pop_front();
        check(rd_valid && rd_data == e, req, int'(rd_data), int'(e));
        rd_next = 1'b1;
        @(negedge rd_clk);
        rd_next = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge wr_clk);
        check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        check(wr_err == 1'b0, "R1 wr_err", int'(wr_err), 0);
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        check(rd_err == 1'b0, "R1 rd_err", int'(rd_err), 0);
    endtask

    task automatic t_partial;
        bit seen = 1'b0;
        for (int i = 0; i < BW - 1; i++) push(DW'(16'hA100 + i), "R3 push");
        for (int i = 0; i < 40; i++) begin
            @(negedge rd_clk);
            if (rd_valid) seen = 1'b1;
        end
        check(!seen, "R3 partial block hidden", int'(seen), 0);
        push(DW'(16'hA1FF), "R3 push last");
        for (int i = 0; i < BW; i++) pop_check("R4 block visible after commit, R2 order");
    endtask

    task automatic t_stream;
        int n = 0;
        for (int i = 0; i < BW; i++) push(DW'(16'h5A00 ^ (i * 16'h0111)), "R4 push");
        @(negedge rd_clk);
        while (!rd_valid && n < 300) begin
            @(negedge rd_clk);
            n++;
        end
        rd_next = 1'b1;
        for (int i = 0; i < BW; i++) begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            check(rd_valid && rd_data == e, "R4 one word per read clock", int'(rd_data), int'(e));
            @(negedge rd_clk);
        end
        rd_next = 1'b0;
        check(rd_valid == 1'b0, "R4 stream ends with data", int'(rd_valid), 0);
    endtask

    task automatic t_full;
        int n = 0;
        for (int i = 0; i < CAP; i++) push(DW'(16'hC300 + i * 3), "R5 fill");
        @(negedge wr_clk);
        check(wr_ready == 1'b0, "R5 not ready at capacity", int'(wr_ready), 0);
        wr_en   = 1'b1;
        wr_data = 16'hDEAD;
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_err == 1'b1, "R6 wr_err on full write", int'(wr_err), 1);
        for (int i = 0; i < BW; i++) pop_check("R2 drain first block");
        @(negedge wr_clk);
        while (!wr_ready && n < 60) begin
            @(negedge wr_clk);
            n++;
        end
        check(wr_ready == 1'b1, "R8 block returned to writer", int'(wr_ready), 1);
        for (int i = 0; i < CAP - BW; i++) pop_check("R6 rejected word absent, R2 order");
        check(wr_err == 1'b1, "R6 wr_err sticky", int'(wr_err), 1);
    endtask

    task automatic t_read_empty;
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R7 empty before probe", int'(rd_valid), 0);
        rd_next = 1'b1;
        @(negedge rd_clk);
        rd_next = 1'b0;
        check(rd_err == 1'b1, "R7 rd_err on empty read", int'(rd_err), 1);
        check(rd_valid == 1'b0, "R7 no word produced", int'(rd_valid), 0);
        for (int i = 0; i < BW; i++) push(DW'(16'h7700 + i), "R7 push");
        for (int i = 0; i < BW; i++) pop_check("R7 nothing lost after bad read");
        check(rd_err == 1'b1, "R7 rd_err sticky", int'(rd_err), 1);
    endtask

    task automatic t_wrap;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < CAP; i++) push(DW'((r * 16'h1111) ^ (i * 16'h0F0F) ^ 16'h8001), "R2 wrap push");
            for (int i = 0; i < CAP; i++) pop_check("R2 wrap order");
        end
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #33 rst_n = 1'b1;
        t_reset();
        t_partial();
        t_stream();
        t_full();
        t_read_empty();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule